// File: doc/BRIEF.md
# I2C Bus Clock and Data Edge Timer

This block paces the bus for an I2C master. While the controller is enabled it drives SCL through alternating low and high phases. Their lengths come from one of two programmable count pairs, one for standard speed and one for fast speed, counted in cycles of the controller clock. It also tells the byte engine when to sample SDA, with a one-cycle pulse in the middle of each high phase. It tells the byte engine when to change SDA, with a one-cycle pulse inside each low phase, placed by a hold count and limited by a setup count.

Configuration is captured only while the controller is disabled, and every count too small to be legal is raised to its floor. The high phase counts only cycles in which SCL is read back high, so a slow rise on the wire lengthens the high phase and does not shorten it.

Top module: `i2c_scl_sda_timer`

## Requirements
- R1: After reset, and one cycle after `enable` is seen low, `scl_out` is 1 and both `sample_stb` and `launch_stb` are 0; on the first enabled cycle a low phase starts.
- R2: With `fast_sel`=1 and `std_sel`=0 the fast count pair sets the phase lengths; in every other combination the standard pair does.
- R3: The high phase lasts max(high count, 6) counted cycles.
- R4: The low phase lasts max(low count, 8) cycles.
- R5: A high-phase cycle counts only once `scl_in` has been seen high in that phase; each earlier cycle in which `scl_in` is low adds one cycle to the high phase.
- R6: `sample_stb` pulses for exactly one cycle per high phase, on counted high cycle floor(H/2), where H is the effective high length.
- R7: `sda_hold_cfg[8]` enables the hold and `sda_hold_cfg[7:0]` holds its count N. The launch pulse comes once per low phase, on low cycle N (counting the first low cycle as 0) when the hold is enabled and on low cycle 0 when it is disabled. The data pin, registered by the byte engine, changes N+1 cycles after SCL falls.
- R8: With S = `sda_setup_cnt`, a value of 0 acting as 1, the launch cycle is never later than L − S (0 if that is negative), where L is the effective low length. This leaves S − 1 cycles of data setup before SCL rises.
- R9: Changes to any count, speed or hold input while `enable` is high have no effect until `enable` has been low for at least one cycle.
- R10: The SCL period, with `scl_in` following `scl_out`, is the effective high length plus the effective low length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enabled; configuration is captured while low |
| std_sel | input | 1 | Standard-speed select |
| fast_sel | input | 1 | Fast-speed select |
| std_high_cnt | input | 16 | Standard-speed high-phase count |
| std_low_cnt | input | 16 | Standard-speed low-phase count |
| fast_high_cnt | input | 16 | Fast-speed high-phase count |
| fast_low_cnt | input | 16 | Fast-speed low-phase count |
| sda_setup_cnt | input | 8 | SDA setup count |
| sda_hold_cfg | input | 9 | Bit 8 hold enable, bits 7:0 hold count |
| scl_in | input | 1 | SCL level read back from the bus |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sample_stb | output | 1 | One-cycle pulse: sample SDA now |
| launch_stb | output | 1 | One-cycle pulse: change SDA now |

## Verification
The assertions assume that configuration inputs move only while `enable` is low. They also assume that `scl_in` is low whenever `scl_out` is low, as it is on a wired-AND bus. The stimulus changes configuration only with the controller disabled, except in the one deliberate test of that rule, and it derives `scl_in` from `scl_out` ANDed with a bench-controlled stretch flag. Under those inputs the frozen-configuration and phase-ordering properties describe legal traffic only.

// File: rtl/i2c_tg_pkg.sv
// Shared types and helpers for the I2C bus clock and data edge timer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package i2c_tg_pkg;

    // Phase of the SCL waveform generator.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

endpackage

// File: rtl/tg_cfg_latch.sv
// Captures the timing configuration while the controller is disabled and
// turns it into effective phase lengths and strobe positions.
// Assumes CW > SUW so an 8-bit setup or hold count fits in a phase count.
module tg_cfg_latch #(
    parameter int CW       = 16,
    parameter int SUW      = 8,
    parameter int MIN_HIGH = 6,
    parameter int MIN_LOW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           std_sel,
    input  logic           fast_sel,
    input  logic [CW-1:0]  std_hi,
    input  logic [CW-1:0]  std_lo,
    input  logic [CW-1:0]  fst_hi,
    input  logic [CW-1:0]  fst_lo,
    input  logic [SUW-1:0] setup_cnt,
    input  logic [SUW:0]   hold_word,
    output logic [CW-1:0]  hi_len,
    output logic [CW-1:0]  lo_len,
    output logic [CW-1:0]  samp_at,
    output logic [CW-1:0]  launch_at
);

    localparam logic [CW-1:0] HI_FLOOR = CW'(MIN_HIGH);
    localparam logic [CW-1:0] LO_FLOOR = CW'(MIN_LOW);

    logic          use_fast;
    logic [CW-1:0] raw_hi, raw_lo, eff_hi, eff_lo;
    logic [CW-1:0] su_eff, room, hold_idx, launch_nx;

    // Pick the speed pair and raise each count to its floor.
    always_comb begin
        use_fast = fast_sel & ~std_sel;
        raw_hi   = use_fast ? fst_hi : std_hi;
        raw_lo   = use_fast ? fst_lo : std_lo;
        eff_hi   = (raw_hi < HI_FLOOR) ? HI_FLOOR : raw_hi;
        eff_lo   = (raw_lo < LO_FLOOR) ? LO_FLOOR : raw_lo;
    end

    // Place the launch cycle: hold count first, then pulled in by setup.
    always_comb begin
        su_eff    = (setup_cnt == '0) ? CW'(1) : CW'(setup_cnt);
        room      = (eff_lo >= su_eff) ? (eff_lo - su_eff) : '0;
        hold_idx  = hold_word[SUW] ? CW'(hold_word[SUW-1:0]) : '0;
        launch_nx = (hold_idx < room) ? hold_idx : room;
    end

    // Hold the captured values while enabled; track inputs while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len    <= HI_FLOOR;
            lo_len    <= LO_FLOOR;
            samp_at   <= HI_FLOOR >> 1;
            launch_at <= '0;
        end else if (!enable) begin
            hi_len    <= eff_hi;
            lo_len    <= eff_lo;
            samp_at   <= eff_hi >> 1;
            launch_at <= launch_nx;
        end
    end

    assert_hi_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len >= HI_FLOOR);

    assert_lo_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_len >= LO_FLOOR);

    assert_launch_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_at < lo_len);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |->
            ($stable(hi_len) && $stable(lo_len) && $stable(launch_at) && $stable(samp_at)));

endmodule

// File: rtl/tg_phase_ctr.sv
// Runs the SCL low/high phase counter and raises the sample and launch
// strobes. Assumes the configuration inputs are stable while enabled and
// that scl_in reads low whenever scl_out drives low.
module tg_phase_ctr
    import i2c_tg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          scl_in,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] samp_at,
    input  logic [CW-1:0] launch_at,
    output logic          scl_out,
    output logic          sample_stb,
    output logic          launch_stb
);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          hi_adv;

    // A high cycle counts once the bus has been seen high in this phase.
    always_comb begin
        hi_adv     = (phase == PH_HIGH) && ((cnt != '0) || scl_in);
        scl_out    = (phase != PH_LOW);
        sample_stb = hi_adv && (cnt == samp_at);
        launch_stb = (phase == PH_LOW) && (cnt == launch_at);
    end

    // Step through idle, low and high phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (cnt == lo_len - CW'(1)) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (hi_adv) begin
                        if (cnt == hi_len - CW'(1)) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !sample_stb && !launch_stb));

    assert_wait_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_HIGH && cnt == '0 && !scl_in) |=> scl_out);

    assert_sample_in_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_out);

    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, launch_stb}));

    assert_launch_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> !scl_out);

    assert_launch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> !launch_stb);

endmodule

// File: rtl/i2c_scl_sda_timer.sv
// Top of the I2C bus clock and data edge timer: configuration capture
// followed by the phase counter. Assumes configuration moves only while
// enable is low and scl_in is the wired-AND bus level of SCL.
module i2c_scl_sda_timer #(
    parameter int CW       = 16,
    parameter int SUW      = 8,
    parameter int MIN_HIGH = 6,
    parameter int MIN_LOW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           std_sel,
    input  logic           fast_sel,
    input  logic [CW-1:0]  std_high_cnt,
    input  logic [CW-1:0]  std_low_cnt,
    input  logic [CW-1:0]  fast_high_cnt,
    input  logic [CW-1:0]  fast_low_cnt,
    input  logic [SUW-1:0] sda_setup_cnt,
    input  logic [SUW:0]   sda_hold_cfg,
    input  logic           scl_in,
    output logic           scl_out,
    output logic           sample_stb,
    output logic           launch_stb
);

    logic [CW-1:0] hi_len, lo_len, samp_at, launch_at;

    tg_cfg_latch #(
        .CW(CW), .SUW(SUW), .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .std_sel   (std_sel),
        .fast_sel  (fast_sel),
        .std_hi    (std_high_cnt),
        .std_lo    (std_low_cnt),
        .fst_hi    (fast_high_cnt),
        .fst_lo    (fast_low_cnt),
        .setup_cnt (sda_setup_cnt),
        .hold_word (sda_hold_cfg),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .samp_at   (samp_at),
        .launch_at (launch_at)
    );

    tg_phase_ctr #(
        .CW(CW)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .scl_in     (scl_in),
        .hi_len     (hi_len),
        .lo_len     (lo_len),
        .samp_at    (samp_at),
        .launch_at  (launch_at),
        .scl_out    (scl_out),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb)
    );

endmodule

// File: tb/sim_i2c_scl_sda_timer.sv
module sim_i2c_scl_sda_timer;

    localparam int CLK_NS = 20;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        enable = 0;
    logic        std_sel = 1, fast_sel = 0;
    logic [15:0] std_high_cnt = 0, std_low_cnt = 0, fast_high_cnt = 0, fast_low_cnt = 0;
    logic [7:0]  sda_setup_cnt = 1;
    logic [8:0]  sda_hold_cfg = 0;
    logic        stretch = 0;
    logic        scl_in;
    logic        scl_out, sample_stb, launch_stb;

    int checks = 0;
    int failures = 0;

    assign scl_in = scl_out & ~stretch;

    always #(CLK_NS/2) clk = ~clk;

    i2c_scl_sda_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .std_sel(std_sel), .fast_sel(fast_sel),
        .std_high_cnt(std_high_cnt), .std_low_cnt(std_low_cnt),
        .fast_high_cnt(fast_high_cnt), .fast_low_cnt(fast_low_cnt),
        .sda_setup_cnt(sda_setup_cnt), .sda_hold_cfg(sda_hold_cfg),
        .scl_in(scl_in), .scl_out(scl_out),
        .sample_stb(sample_stb), .launch_stb(launch_stb)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Disable, load every configuration input, then enable again.
    task automatic configure(input bit sb, input bit fb, input int sh, input int sl,
                             input int fh, input int fl, input bit hen,
                             input int hold, input int su);
        @(negedge clk);
        enable        = 0;
        std_sel       = sb;
        fast_sel      = fb;
        std_high_cnt  = 16'(sh);
        std_low_cnt   = 16'(sl);
        fast_high_cnt = 16'(fh);
        fast_low_cnt  = 16'(fl);
        sda_hold_cfg  = {hen, 8'(hold)};
        sda_setup_cnt = 8'(su);
        @(negedge clk);
        @(negedge clk);
        enable = 1;
    endtask

    // Skip to the start of a low phase, then time one full period.
    task automatic measure(input int st_n, output int lo, output int hi,
                           output int li, output int si);
        @(negedge clk);
        while (scl_out == 0) @(negedge clk);
        while (scl_out == 1) @(negedge clk);
        lo = 0; li = -1;
        while (scl_out == 0) begin
            if (launch_stb) li = lo;
            lo++;
            @(negedge clk);
        end
        hi = 0; si = -1;
        while (scl_out == 1) begin
            if (sample_stb) si = hi;
            stretch = (hi < st_n);
            hi++;
            @(negedge clk);
        end
        stretch = 0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lo, hi, li, si, eh, el, el2, sue, room;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset and disabled state
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(scl_out, 1, "R1", "scl_out after reset");
            check(sample_stb | launch_stb, 0, "R1", "strobes after reset");
        end

        // R2 R3 R4 R6 R10: sweep both speeds over small counts, decoy on the other pair
        for (int fast = 0; fast < 2; fast++) begin
            for (int h = 0; h < 10; h++) begin
                for (int l = 0; l < 12; l++) begin
                    if (fast == 1) configure(0, 1, h + 20, l + 21, h, l, 1, 2, 3);
                    else           configure(1, 0, h, l, h + 20, l + 21, 1, 2, 3);
                    measure(0, lo, hi, li, si);
                    eh = imax(h, 6);
                    el = imax(l, 8);
                    check(lo, el, "R4", "low phase length");
                    check(hi, eh, "R3", "high phase length");
                    check(si, eh / 2, "R6", "sample position");
                    check(li, 2, "R7", "launch position");
                    check(lo + hi, eh + el, "R10", "period");
                end
            end
        end

        // R2: both select bits set and neither set fall back to standard
        configure(1, 1, 9, 10, 30, 31, 0, 0, 1);
        measure(0, lo, hi, li, si);
        check(hi, 9, "R2", "both bits high length");
        check(lo, 10, "R2", "both bits low length");
        configure(0, 0, 7, 11, 30, 31, 0, 0, 1);
        measure(0, lo, hi, li, si);
        check(hi, 7, "R2", "no bits high length");
        check(lo, 11, "R2", "no bits low length");

        // R7 R8: sweep hold enable, hold count and setup count at low length 12
        for (int hen = 0; hen < 2; hen++) begin
            for (int hold = 0; hold < 13; hold++) begin
                for (int su = 0; su < 15; su++) begin
                    configure(1, 0, 6, 12, 40, 40, hen[0], hold, su);
                    measure(0, lo, hi, li, si);
                    sue  = (su == 0) ? 1 : su;
                    room = imax(12 - sue, 0);
                    el2  = imin((hen != 0) ? hold : 0, room);
                    check(li, el2, (hen != 0 && hold > room) || su == 0 ? "R8" : "R7",
                          "launch position");
                end
            end
        end
        // R8: large hold with large setup clamps to the low phase start
        configure(1, 0, 6, 8, 40, 40, 1, 255, 255);
        measure(0, lo, hi, li, si);
        check(li, 0, "R8", "launch with setup above low length");

        // R5: hold scl_in low at the start of the high phase
        configure(1, 0, 7, 8, 40, 40, 0, 0, 1);
        measure(5, lo, hi, li, si);
        check(hi, 12, "R5", "stretched high length");
        check(si, 8, "R5", "stretched sample position");
        measure(1, lo, hi, li, si);
        check(hi, 8, "R5", "one-cycle stretch high length");

        // R9: writes while enabled are ignored until the next disable
        configure(1, 0, 10, 9, 40, 40, 1, 1, 1);
        measure(0, lo, hi, li, si);
        check(hi, 10, "R9", "high before write");
        @(negedge clk);
        std_high_cnt = 20; std_low_cnt = 21; sda_hold_cfg = 9'h104; fast_sel = 1; std_sel = 0;
        measure(0, lo, hi, li, si);
        check(hi, 10, "R9", "high after live write");
        check(lo, 9, "R9", "low after live write");
        check(li, 1, "R9", "launch after live write");
        configure(1, 0, 20, 21, 40, 40, 1, 4, 1);
        measure(0, lo, hi, li, si);
        check(hi, 20, "R9", "high after re-enable");
        check(li, 4, "R9", "launch after re-enable");

        // R1: disabling mid-run releases SCL and silences strobes
        @(negedge clk);
        enable = 0;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            check(scl_out, 1, "R1", "scl_out while disabled");
            check(sample_stb | launch_stb, 0, "R1", "strobes while disabled");
            @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule